// File: doc/BRIEF.md
# Vector Register Arithmetic Sequencer

This block keeps a small bank of vector registers and executes element-wise integer instructions on them. An instruction names an operation, one destination register and two source registers. Once accepted, the sequencer walks element indices upward from zero, one per clock. It stops after the number of elements held in a run-time length register. Each element's result goes through a one-stage result register before it is written back. A per-element enable mask can suppress the write of any element.

Software, or a neighbouring control unit, sets the length and the mask through their own write strobes and then issues instructions through a valid/ready handshake. The length and the mask are sampled together with the instruction. A new setting therefore applies from the next accepted instruction onward. A single-cycle completion pulse marks the end of every legal instruction, and a single-cycle error pulse answers an illegal operation code. A combinational debug port reads any element of any register at any time.

Each register holds 64 elements of 64 bits, and there are 8 registers. The result register between the read and the write keeps the datapath depth at one adder per cycle. Elements of one instruction never depend on each other, so the element stream runs with no hazard checks.

Top module: `vseq_top`

## Requirements
- R1: After reset the block is idle (busy, done and err low, issue_ready high), the length is 64, every mask bit is 1, and element i of register r holds ((r*64 + i + 1) * 0x9E3779B97F4A7C15) modulo 2^64.
- R2: The operation code selects the result, computed modulo 2^64: 0 gives vs1+vs2, 1 gives vs1-vs2, 2 gives vs1 AND vs2, 3 gives vs1 OR vs2, 4 gives vs1 XOR vs2.
- R3: An instruction processes element indices 0 to L-1, where L is the stored length. Elements of the destination at index L or above keep their earlier values.
- R4: Bit i of the mask word gates element i. When the bit is 0, element i of the destination keeps its earlier value.
- R5: An instruction accepted with L>0 holds busy high for exactly L+1 cycles after the accepting edge. In the first cycle busy is low again, done is high for that one cycle and all results can be read on the debug port.
- R6: A length write above 64 stores 64.
- R7: An instruction accepted with L=0 raises done in the cycle right after acceptance, never raises busy, and writes nothing.
- R8: Operation codes 5, 6 and 7 raise err for the one cycle right after acceptance, leave busy and done low, and write nothing.
- R9: issue_ready is low while busy is high. issue_valid during that time is ignored: no extra instruction runs and no register changes because of it.
- R10: The length and the mask are captured when an instruction is accepted. Writes to them while that instruction runs only affect later instructions.
- R11: The destination may be one of the sources. Each element result is formed from the source values that were present before the instruction began.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction can be accepted this cycle |
| issue_op | input | 3 | Operation code |
| issue_vd | input | 3 | Destination register |
| issue_vs1 | input | 3 | First source register |
| issue_vs2 | input | 3 | Second source register |
| vl_we | input | 1 | Length write strobe |
| vl_wdata | input | 8 | Requested length (clamped to 64) |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 64 | Mask word, bit i gates element i |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-operation pulse |
| dbg_reg | input | 3 | Debug read register select |
| dbg_idx | input | 6 | Debug read element select |
| dbg_data | output | 64 | Debug read data (combinational) |

## Verification
Call the accepting edge E0. For a legal instruction with length L>0, busy is due in the cycle after E0 and stays high through L+1 cycles. The done pulse and the final register contents are due in the first cycle after that. A zero-length instruction has done due in the cycle after E0, and an illegal one has err due in that same cycle. The bench drives and samples on the falling edge and counts busy cycles one falling edge at a time against L+1. It checks done exactly where busy drops and reads the whole register bank back through the combinational debug port only after done. Writes to the length and mask, and extra issue attempts, happen inside the busy window so that the effect of their timing can be seen.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    VOP_ADD = 3'd0,
    VOP_SUB = 3'd1,
    VOP_AND = 3'd2,
    VOP_OR  = 3'd3,
    VOP_XOR = 3'd4
  } vop_e;

  // Reset contents of an element: an odd-constant multiplicative spread of its
  // linear position, so every element starts distinct and non-zero.
  function automatic logic [63:0] seed_elem(input int unsigned r,
                                            input int unsigned i,
                                            input int unsigned depth);
    logic [63:0] pos;
    pos = 64'(r * depth + i + 1);
    return pos * 64'h9E37_79B9_7F4A_7C15;
  endfunction

endpackage

// File: rtl/vseq_alu.sv
module vseq_alu #(
  parameter int W = 64
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import vseq_pkg::*;

  always_comb begin
    case (vop_e'(op))
      VOP_ADD: y = a + b;
      VOP_SUB: y = a - b;
      VOP_AND: y = a & b;
      VOP_OR:  y = a | b;
      VOP_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/vseq_vrf.sv
module vseq_vrf #(
  parameter int NREG  = 8,
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_reg_a,
  input  logic [RW-1:0] rd_reg_b,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [RW-1:0] wr_reg,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [RW-1:0] dbg_reg,
  input  logic [IW-1:0] dbg_idx,
  output logic [W-1:0]  dbg_data
);
  import vseq_pkg::*;

  logic [W-1:0] sel_a [NREG];
  logic [W-1:0] sel_b [NREG];
  logic [W-1:0] sel_d [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] row [DEPTH];
    logic         row_we;

    assign row_we = we && (wr_reg == RW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) row[i] <= W'(seed_elem(g, i, DEPTH));
      end else if (row_we) begin
        row[wr_idx] <= wr_data;
      end
    end

    assign sel_a[g] = row[rd_idx];
    assign sel_b[g] = row[rd_idx];
    assign sel_d[g] = row[dbg_idx];
  end

  assign rd_a     = sel_a[rd_reg_a];
  assign rd_b     = sel_b[rd_reg_b];
  assign dbg_data = sel_d[dbg_reg];
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          elem_valid,
  output logic [IW-1:0] elem_idx,
  output logic [LW-1:0] len_q,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  state_e        state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (go) begin
          idx_d = '0;
          len_d = len;
          if (len == '0) done_d  = 1'b1;
          else           state_d = S_RUN;
        end
      end
      S_RUN: begin
        if (LW'(idx_q) + LW'(1) == len_q) state_d = S_DRAIN;
        else                              idx_d   = idx_q + IW'(1);
      end
      S_DRAIN: begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign elem_valid = (state_q == S_RUN);
  assign elem_idx   = idx_q;
  assign done       = done_q;
endmodule

// File: rtl/vseq_top.sv
module vseq_top #(
  parameter int NREG    = 8,
  parameter int DEPTH   = 64,
  parameter int W       = 64,
  parameter int VLIN_W  = 8,
  localparam int RW     = $clog2(NREG),
  localparam int IW     = $clog2(DEPTH),
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [2:0]        issue_op,
  input  logic [RW-1:0]     issue_vd,
  input  logic [RW-1:0]     issue_vs1,
  input  logic [RW-1:0]     issue_vs2,
  input  logic              vl_we,
  input  logic [VLIN_W-1:0] vl_wdata,
  input  logic              mask_we,
  input  logic [DEPTH-1:0]  mask_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [RW-1:0]     dbg_reg,
  input  logic [IW-1:0]     dbg_idx,
  output logic [W-1:0]      dbg_data
);
  import vseq_pkg::*;

  // reset synchroniser: asserts at once, releases on the second edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // architectural length and mask
  logic [LW-1:0]    vl_q, vl_d;
  logic [DEPTH-1:0] mask_q, mask_d;

  always_comb begin
    vl_d   = vl_q;
    mask_d = mask_q;
    if (vl_we)   vl_d   = (vl_wdata > VLIN_W'(DEPTH)) ? LW'(DEPTH) : LW'(vl_wdata);
    if (mask_we) mask_d = mask_wdata;
  end

  // issue handshake
  logic accept, op_ok, go;
  assign issue_ready = rst_int_n && !busy;
  assign accept      = issue_valid && issue_ready;
  assign op_ok       = (issue_op <= 3'(VOP_XOR));
  assign go          = accept && op_ok;

  // captured instruction
  logic [2:0]       op_q;
  logic [RW-1:0]    vd_q, vs1_q, vs2_q;
  logic [DEPTH-1:0] msk_snap_q;
  logic             err_q, err_d;

  assign err_d = accept && !op_ok;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vl_q       <= LW'(DEPTH);
      mask_q     <= '1;
      op_q       <= '0;
      vd_q       <= '0;
      vs1_q      <= '0;
      vs2_q      <= '0;
      msk_snap_q <= '0;
      err_q      <= 1'b0;
    end else begin
      if (vl_we)   vl_q   <= vl_d;
      if (mask_we) mask_q <= mask_d;
      if (accept) begin
        op_q       <= issue_op;
        vd_q       <= issue_vd;
        vs1_q      <= issue_vs1;
        vs2_q      <= issue_vs2;
        msk_snap_q <= mask_q;
      end
      err_q <= err_d;
    end
  end

  // element sequencer
  logic          elem_valid;
  logic [IW-1:0] elem_idx;
  logic [LW-1:0] cur_len;

  vseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go         (go),
    .len        (vl_q),
    .busy       (busy),
    .elem_valid (elem_valid),
    .elem_idx   (elem_idx),
    .len_q      (cur_len),
    .done       (done)
  );

  // register bank and datapath
  logic [W-1:0]  src_a, src_b, alu_y;
  logic          wb_valid_q;
  logic [IW-1:0] wb_idx_q;
  logic [W-1:0]  wb_data_q;
  logic          vrf_we;

  assign vrf_we = wb_valid_q && msk_snap_q[wb_idx_q];

  vseq_vrf #(.NREG(NREG), .DEPTH(DEPTH), .W(W)) u_vrf (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_reg_a (vs1_q),
    .rd_reg_b (vs2_q),
    .rd_idx   (elem_idx),
    .rd_a     (src_a),
    .rd_b     (src_b),
    .we       (vrf_we),
    .wr_reg   (vd_q),
    .wr_idx   (wb_idx_q),
    .wr_data  (wb_data_q),
    .dbg_reg  (dbg_reg),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
  );

  vseq_alu #(.W(W)) u_alu (
    .op (op_q),
    .a  (src_a),
    .b  (src_b),
    .y  (alu_y)
  );

  // one-stage result register between read and write-back
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= elem_valid;
      if (elem_valid) begin
        wb_idx_q  <= elem_idx;
        wb_data_q <= alu_y;
      end
    end
  end

  assign err = err_q;
endmodule

// File: rtl/vseq_check.sv
module vseq_check #(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic [2:0]    issue_op,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [LW-1:0] vl_q,
  input logic [LW-1:0] cur_len,
  input logic [IW-1:0] wb_idx,
  input logic          vrf_we,
  input logic [2:0]    op_q
);
  logic acc;
  assign acc = issue_valid && issue_ready;

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_op <= 3'd4 && vl_q != '0) |=> busy);

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_op <= 3'd4 && vl_q == '0) |=> (done && !busy));

  assert_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_op > 3'd4) |=> (err && !busy && !done));

  assert_len_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= LW'(DEPTH));

  assert_write_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> (LW'(wb_idx) < cur_len));

  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && issue_valid) |=> $stable(op_q));
endmodule

bind vseq_top vseq_check #(.DEPTH(DEPTH)) u_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_op    (issue_op),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .vl_q        (vl_q),
  .cur_len     (cur_len),
  .wb_idx      (wb_idx_q),
  .vrf_we      (vrf_we),
  .op_q        (op_q)
);

// File: tb/vseq_top_test.sv
`timescale 1ns/1ps
module vseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [2:0]  issue_op, issue_vd, issue_vs1, issue_vs2;
  logic        vl_we;
  logic [7:0]  vl_wdata;
  logic        mask_we;
  logic [63:0] mask_wdata;
  logic        busy, done, err;
  logic [2:0]  dbg_reg;
  logic [5:0]  dbg_idx;
  logic [63:0] dbg_data;

  always #2 clk = ~clk;

  vseq_top uut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
    .vl_we(vl_we), .vl_wdata(vl_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .busy(busy), .done(done), .err(err),
    .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  int unsigned n_cmp = 0;
  int unsigned n_mis = 0;
  bit          finished = 0;

  longint unsigned model [8][64];
  int              vl_m;
  logic [63:0]     mask_m;

  function automatic longint unsigned seedv(int r, int i);
    longint unsigned p;
    p = longint'(r * 64 + i + 1);
    return p * 64'h9E3779B97F4A7C15;
  endfunction

  function automatic longint unsigned opres(int op, longint unsigned a, longint unsigned b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic dump_check(string req);
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 64; i++) begin
        dbg_reg = 3'(r);
        dbg_idx = 6'(i);
        #0.5;
        check_eq(req, dbg_data, model[r][i]);
      end
    end
  endtask

  task automatic set_vl(int v);
    @(negedge clk);
    vl_we = 1'b1; vl_wdata = 8'(v);
    @(negedge clk);
    vl_we = 1'b0;
    vl_m = (v > 64) ? 64 : v;
  endtask

  task automatic set_mask(logic [63:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
    mask_m = m;
  endtask

  // mode 0: plain; 1: rewrite length/mask in first busy cycle (R10);
  // 2: keep offering another instruction during busy (R9)
  task automatic do_instr(int op, int vd, int vs1, int vs2, int mode, int pvl, logic [63:0] pmask);
    int cnt;
    @(negedge clk);
    check_eq("R9 ready before issue", 64'(issue_ready), 64'd1);
    issue_valid = 1'b1;
    issue_op = 3'(op); issue_vd = 3'(vd); issue_vs1 = 3'(vs1); issue_vs2 = 3'(vs2);
    @(negedge clk);
    issue_valid = 1'b0;
    if (op > 4) begin
      check_eq("R8 err pulse", 64'({err, busy, done}), 64'b100);
      @(negedge clk);
      check_eq("R8 err single", 64'(err), 64'd0);
    end else if (vl_m == 0) begin
      check_eq("R7 zero length done", 64'({busy, done}), 64'b01);
      @(negedge clk);
      check_eq("R7 done single", 64'(done), 64'd0);
    end else begin
      cnt = 0;
      while (busy === 1'b1 && cnt < 200) begin
        if (cnt == 0) check_eq("R9 ready low while busy", 64'(issue_ready), 64'd0);
        if (mode == 1 && cnt == 0) begin
          vl_we = 1'b1; vl_wdata = 8'(pvl); mask_we = 1'b1; mask_wdata = pmask;
        end
        if (mode == 2 && cnt == 0) begin
          issue_valid = 1'b1; issue_op = 3'd4; issue_vd = 3'(vs1); issue_vs1 = 3'(vd); issue_vs2 = 3'(vs2);
        end
        if (cnt == 1) begin vl_we = 1'b0; mask_we = 1'b0; end
        if (mode == 2 && cnt == 2) issue_valid = 1'b0;
        cnt++;
        @(negedge clk);
      end
      check_eq("R5 busy cycles", 64'(cnt), 64'(vl_m + 1));
      check_eq("R5 done when busy falls", 64'(done), 64'd1);
      for (int i = 0; i < vl_m; i++)
        if (mask_m[i]) model[vd][i] = opres(op, model[vs1][i], model[vs2][i]);
      @(negedge clk);
      check_eq("R5 done single", 64'(done), 64'd0);
      if (mode == 1) begin
        vl_m = (pvl > 64) ? 64 : pvl;
        mask_m = pmask;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_mis++;
      $display("FAIL R5 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_vd = '0; issue_vs1 = '0; issue_vs2 = '0;
    vl_we = 1'b0; vl_wdata = '0; mask_we = 1'b0; mask_wdata = '0; dbg_reg = '0; dbg_idx = '0;
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) model[r][i] = seedv(r, i);
    vl_m = 64; mask_m = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and seeded contents
    check_eq("R1 idle after reset", 64'({busy, done, err, issue_ready}), 64'b0001);
    dump_check("R1 reset contents");

    // R1 R2: default length 64, full mask, every operation
    for (int op = 0; op < 5; op++) begin
      do_instr(op, (op + 3) % 8, op % 8, (op + 1) % 8, 0, 0, '0);
      dump_check("R2 operation result");
    end

    // R3 R4: short length with sparse mask
    set_vl(5);
    set_mask(64'h0000_0000_0000_0015);
    do_instr(0, 2, 4, 5, 0, 0, '0);
    dump_check("R3 R4 length and mask gating");

    // R11: destination equals both sources
    set_mask('1);
    set_vl(17);
    do_instr(1, 6, 6, 7, 0, 0, '0);
    do_instr(0, 3, 3, 3, 0, 0, '0);
    dump_check("R11 overlapping operands");

    // R6: clamp
    set_vl(100);
    do_instr(4, 1, 2, 3, 0, 0, '0);
    dump_check("R6 clamped length");

    // R7: zero length
    set_vl(0);
    do_instr(0, 0, 1, 2, 0, 0, '0);
    dump_check("R7 no writes");

    // R8: illegal codes
    set_vl(9);
    do_instr(5, 0, 1, 2, 0, 0, '0);
    do_instr(7, 4, 4, 4, 0, 0, '0);
    dump_check("R8 no writes");

    // R10: length and mask rewritten mid-instruction
    set_vl(10);
    do_instr(3, 5, 0, 1, 1, 3, 64'h0);
    dump_check("R10 running instruction unaffected");
    do_instr(0, 5, 5, 5, 0, 0, '0);
    check_eq("R10 new length applied", 64'(vl_m), 64'd3);
    dump_check("R10 new mask applied");

    // R9: offer during busy is ignored
    set_mask('1);
    set_vl(8);
    do_instr(2, 0, 6, 7, 2, 0, '0);
    repeat (2) @(negedge clk);
    check_eq("R9 no extra instruction", 64'({busy, done}), 64'b00);
    dump_check("R9 ignored offer");

    // constrained random mix
    for (int k = 0; k < 30; k++) begin
      if ($urandom % 2) set_vl($urandom % 81);
      if ($urandom % 2) set_mask({$urandom, $urandom});
      do_instr($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, 0, 0, '0);
      dump_check("R2 R3 R4 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule